// File: doc/BRIEF.md
# UART Receive Line-Error Flags

This block sits beside a UART receiver and turns the status of each received character into two line-status error flags: a framing-error flag and a break flag. The receiver's bit engine supplies the sampled first stop bit, the data bits, the optional parity bit and a strobe that marks the stop-bit sample. Without a receive FIFO, the flags take the character's status at that strobe. With a FIFO, the block returns the per-character status on `char_fe`/`char_bi` so the FIFO can store it with the data. It takes that status back on `ent_fe`/`ent_bi` when the entry moves into the receive buffer register on `buf_load`.

The flags are sticky. Software clears them by writing ones to their bit positions. A data-ready flag is set in the same cycle as the error flags, and a buffer read clears it. A test control, `force_bad_stop`, makes every stop bit count as invalid, so that software can produce framing errors on purpose.

Top module: `uart_rx_errflags`

## Requirements
- R1: With `fifo_en` low, a `stop_strobe` whose effective stop bit is low sets `fe_flag` on the next clock edge. A high stop bit leaves the flags unchanged.
- R2: `char_bi` is high only when the effective stop bit is low and every data bit inside the configured length is low. The length is set by `data_len`: 0, 1, 2 and 3 mean 5, 6, 7 and 8 bits, using `rx_word[4:0]` up to `rx_word[7:0]`, and higher bits are ignored. When `par_en` is high, `rx_parity` must also be low. `bi_flag` takes `char_bi` at the load event, in the same way that `fe_flag` takes `char_fe`.
- R3: When `par_en` is low, `rx_parity` has no effect on `char_bi`.
- R4: All three flags are sticky. A later error-free character does not clear them.
- R5: A cycle with `clr_wr` high clears `fe_flag` if `clr_data[0]` is 1 and clears `bi_flag` if `clr_data[1]` is 1. A 0 bit leaves its flag unchanged.
- R6: When a set and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: While `force_bad_stop` is high, the stop bit is treated as low whatever `stop_bit` is.
- R8: With `fifo_en` high, `stop_strobe` does not change the flags. `char_fe`/`char_bi` are the status to store with the character. On `buf_load`, the flags take `ent_fe`/`ent_bi`.
- R9: `dr_flag` is set by the same load event that updates the error flags, on the same edge. `rd_ack` clears it, and a simultaneous load keeps it set.
- R10: After reset, `fe_flag`, `bi_flag` and `dr_flag` are 0.
- R11: With `fifo_en` low, `buf_load` has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Receive FIFO in use |
| par_en | input | 1 | Parity bit present |
| data_len | input | 2 | Data length code, 5 + value bits |
| force_bad_stop | input | 1 | Test control: treat stop bits as invalid |
| stop_strobe | input | 1 | First stop bit sampled this cycle |
| stop_bit | input | 1 | Sampled first stop bit level |
| rx_word | input | 8 | Received data bits, LSB first received |
| rx_parity | input | 1 | Received parity bit |
| buf_load | input | 1 | FIFO entry moves into the buffer register |
| ent_fe | input | 1 | Stored framing status of that entry |
| ent_bi | input | 1 | Stored break status of that entry |
| clr_wr | input | 1 | Write-one-to-clear access to the flags |
| clr_data | input | 2 | Clear mask: bit 0 framing, bit 1 break |
| rd_ack | input | 1 | Buffer register read, clears data-ready |
| char_fe | output | 1 | Framing status of the current character |
| char_bi | output | 1 | Break status of the current character |
| fe_flag | output | 1 | Sticky framing-error flag |
| bi_flag | output | 1 | Sticky break flag |
| dr_flag | output | 1 | Data-ready flag |

## Verification
The assertions check on every cycle that a load event carrying an error sets the flag and raises data-ready, that flags hold when there is neither a load nor a clear, and that a clear without a competing set takes effect. They also check that break status always implies framing status, that forced stop bits always give a framing error, and that in FIFO mode nothing but `buf_load` creates a load event. The bench scenarios are needed to show that the length mask and the parity option select the right bits, and that the exact values come out across the reset state. They also show the ordering of FIFO status that is stored and later applied.

// File: rtl/uart_rxerr_pkg.sv
package uart_rxerr_pkg;
  localparam int FE_POS = 0;
  localparam int BI_POS = 1;
  localparam int NFLAGS = 2;

  // mask of the data bits in use for a length code
  function automatic logic [7:0] len_mask(input logic [1:0] code, input int min_bits);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < min_bits + int'(code)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // break: stop low and all counted bits low
  function automatic logic all_low(input logic stop_eff, input logic [7:0] word,
                                   input logic [7:0] mask, input logic par_on,
                                   input logic par);
    return !stop_eff && ((word & mask) == 8'h00) && !(par_on && par);
  endfunction
endpackage

// File: rtl/rx_char_classify.sv
module rx_char_classify
  import uart_rxerr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = 5
) (
  input  logic              stop_bit,
  input  logic              force_bad_stop,
  input  logic [DATA_W-1:0] word,
  input  logic              parity,
  input  logic              par_en,
  input  logic [LEN_W-1:0]  len,
  output logic              is_fe,
  output logic              is_bi
);
  logic       stop_eff;
  logic [7:0] mask;
  logic [7:0] word8;

  always_comb begin
    stop_eff = stop_bit && !force_bad_stop;
    mask     = len_mask(len, MIN_BITS);
    word8    = 8'(word);
    is_fe    = !stop_eff;
    is_bi    = all_low(stop_eff, word8, mask, par_en, parity);
  end
endmodule

// File: rtl/rx_status_src.sv
module rx_status_src #(
  parameter int NFLAGS = 2
) (
  input  logic              fifo_en,
  input  logic              stop_strobe,
  input  logic              buf_load,
  input  logic [NFLAGS-1:0] char_st,
  input  logic [NFLAGS-1:0] ent_st,
  output logic              load_evt,
  output logic [NFLAGS-1:0] src_st
);
  always_comb begin
    if (fifo_en) begin
      load_evt = buf_load;
      src_st   = ent_st;
    end else begin
      load_evt = stop_strobe;
      src_st   = char_st;
    end
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_errflags.sv
module uart_rx_errflags
  import uart_rxerr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LEN_W    = 2,
  parameter int MIN_BITS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              par_en,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              force_bad_stop,
  input  logic              stop_strobe,
  input  logic              stop_bit,
  input  logic [DATA_W-1:0] rx_word,
  input  logic              rx_parity,
  input  logic              buf_load,
  input  logic              ent_fe,
  input  logic              ent_bi,
  input  logic              clr_wr,
  input  logic [NFLAGS-1:0] clr_data,
  input  logic              rd_ack,
  output logic              char_fe,
  output logic              char_bi,
  output logic              fe_flag,
  output logic              bi_flag,
  output logic              dr_flag
);
  logic              load_evt;
  logic [NFLAGS-1:0] char_st, ent_st, src_st, flag_q, flag_set, flag_clr;

  rx_char_classify #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MIN_BITS(MIN_BITS)) u_cls (
    .stop_bit(stop_bit), .force_bad_stop(force_bad_stop), .word(rx_word),
    .parity(rx_parity), .par_en(par_en), .len(data_len),
    .is_fe(char_fe), .is_bi(char_bi)
  );

  always_comb begin
    char_st         = '0;
    char_st[FE_POS] = char_fe;
    char_st[BI_POS] = char_bi;
    ent_st          = '0;
    ent_st[FE_POS]  = ent_fe;
    ent_st[BI_POS]  = ent_bi;
  end

  rx_status_src #(.NFLAGS(NFLAGS)) u_src (
    .fifo_en(fifo_en), .stop_strobe(stop_strobe), .buf_load(buf_load),
    .char_st(char_st), .ent_st(ent_st), .load_evt(load_evt), .src_st(src_st)
  );

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    assign flag_set[g] = load_evt && src_st[g];
    assign flag_clr[g] = clr_wr && clr_data[g];
    sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clr[g]), .q(flag_q[g])
    );
  end

  sticky_flag u_dr (
    .clk(clk), .rst_n(rst_n), .set(load_evt), .clr(rd_ack), .q(dr_flag)
  );

  assign fe_flag = flag_q[FE_POS];
  assign bi_flag = flag_q[BI_POS];
endmodule

// File: rtl/uart_rx_errflags_chk.sv
module uart_rx_errflags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       force_bad_stop,
  input logic       buf_load,
  input logic       clr_wr,
  input logic [1:0] clr_data,
  input logic       load_evt,
  input logic [1:0] src_st,
  input logic       char_fe,
  input logic       char_bi,
  input logic       fe_flag,
  input logic       bi_flag,
  input logic       dr_flag
);
  AST_FE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && src_st[0] |=> fe_flag); // R1
  AST_BI_IMPLIES_FE: assert property (@(posedge clk) disable iff (!rst_n)
    char_bi |-> char_fe); // R2
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt && !(clr_wr && clr_data[0]) |=> $stable(fe_flag)); // R4
  AST_BI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt && !(clr_wr && clr_data[1]) |=> $stable(bi_flag)); // R4
  AST_FE_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_data[0] && !(load_evt && src_st[0]) |=> !fe_flag); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && src_st[1] && clr_wr && clr_data[1] |=> bi_flag); // R6
  AST_FORCE_FE: assert property (@(posedge clk) disable iff (!rst_n)
    force_bad_stop |-> char_fe); // R7
  AST_FIFO_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && !buf_load |-> !load_evt); // R8
  AST_DR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> dr_flag); // R9
endmodule

bind uart_rx_errflags uart_rx_errflags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .force_bad_stop(force_bad_stop),
  .buf_load(buf_load), .clr_wr(clr_wr), .clr_data(clr_data),
  .load_evt(load_evt), .src_st(src_st), .char_fe(char_fe), .char_bi(char_bi),
  .fe_flag(fe_flag), .bi_flag(bi_flag), .dr_flag(dr_flag)
);

// File: tb/tb_uart_rx_errflags.sv
module tb_uart_rx_errflags;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, par_en = 0, force_bad_stop = 0, stop_strobe = 0, stop_bit = 1;
  logic [1:0] data_len = 2'd3;
  logic [7:0] rx_word = 0;
  logic rx_parity = 0, buf_load = 0, ent_fe = 0, ent_bi = 0, clr_wr = 0, rd_ack = 0;
  logic [1:0] clr_data = 0;
  logic char_fe, char_bi, fe_flag, bi_flag, dr_flag;
  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_rx_errflags dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: expired, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // {len, par_en, parity, force, stop, word, exp_fe, exp_bi}
  localparam logic [15:0] VEC [13] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b1, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hE0, 1'b1, 1'b1},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 1'b1, 1'b0},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 1'b1, 1'b0},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b1, 1'b1},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 1'b1, 1'b0},
    {2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  // drive at negedge, one strobe cycle, return at next negedge
  task automatic pulse_stop();
    stop_strobe = 1;
    @(negedge clk);
    stop_strobe = 0;
  endtask

  task automatic clear_all();
    clr_wr = 1; clr_data = 2'b11; rd_ack = 1;
    @(negedge clk);
    clr_wr = 0; clr_data = 0; rd_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 fe reset", fe_flag, 0);
    chk("R10 bi reset", bi_flag, 0);
    chk("R10 dr reset", dr_flag, 0);
    rst_n = 1;
    @(negedge clk);

    // table walk: R1 R2 R3 R7
    for (int i = 0; i < 13; i++) begin
      {data_len, par_en, rx_parity, force_bad_stop, stop_bit, rx_word} = VEC[i][15:2];
      #1;
      chk("R2/R3/R7 char_fe", char_fe, VEC[i][1]);
      chk("R2/R3/R7 char_bi", char_bi, VEC[i][0]);
      pulse_stop();
      chk("R1 fe_flag", fe_flag, VEC[i][1]);
      chk("R2 bi_flag", bi_flag, VEC[i][0]);
      chk("R9 dr_flag", dr_flag, 1);
      clear_all();
    end
    force_bad_stop = 0; par_en = 0; rx_parity = 0; data_len = 2'd3;

    // R4 sticky: error then good char
    stop_bit = 0; rx_word = 0; pulse_stop();
    stop_bit = 1; rx_word = 8'h41; pulse_stop();
    chk("R4 fe sticky", fe_flag, 1);
    chk("R4 bi sticky", bi_flag, 1);
    // R5 selective clear
    clr_wr = 1; clr_data = 2'b10; @(negedge clk); clr_wr = 0; clr_data = 0;
    chk("R5 fe kept", fe_flag, 1);
    chk("R5 bi cleared", bi_flag, 0);
    clr_wr = 1; clr_data = 2'b00; @(negedge clk); clr_wr = 0;
    chk("R5 zero mask", fe_flag, 1);
    clr_wr = 1; clr_data = 2'b01; @(negedge clk); clr_wr = 0; clr_data = 0;
    chk("R5 fe cleared", fe_flag, 0);

    // R6 set wins
    stop_bit = 0; rx_word = 0; clr_wr = 1; clr_data = 2'b11;
    pulse_stop(); clr_wr = 0; clr_data = 0;
    chk("R6 fe set wins", fe_flag, 1);
    chk("R6 bi set wins", bi_flag, 1);
    clear_all();

    // R9 dr clear and load-vs-read
    chk("R9 dr cleared", dr_flag, 0);
    stop_bit = 1; rd_ack = 1; pulse_stop(); rd_ack = 0;
    chk("R9 load beats read", dr_flag, 1);
    rd_ack = 1; @(negedge clk); rd_ack = 0;
    chk("R9 read clears", dr_flag, 0);

    // R11 buf_load ignored without FIFO
    ent_fe = 1; ent_bi = 1; buf_load = 1; @(negedge clk); buf_load = 0;
    chk("R11 fe", fe_flag, 0);
    chk("R11 bi", bi_flag, 0);
    chk("R11 dr", dr_flag, 0);

    // R8 FIFO mode
    fifo_en = 1; ent_fe = 0; ent_bi = 0;
    stop_bit = 0; rx_word = 0; #1;
    chk("R8 char_bi for store", char_bi, 1);
    pulse_stop();
    chk("R8 strobe no fe", fe_flag, 0);
    chk("R8 strobe no dr", dr_flag, 0);
    ent_fe = 1; ent_bi = 0; buf_load = 1; @(negedge clk); buf_load = 0;
    chk("R8 load fe", fe_flag, 1);
    chk("R8 load bi", bi_flag, 0);
    chk("R8 load dr", dr_flag, 1);
    ent_fe = 1; ent_bi = 1; buf_load = 1; @(negedge clk); buf_load = 0;
    chk("R8 second load bi", bi_flag, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule